// File: doc/BRIEF.md
# FP compare, min-max and sign-injection unit

This is a purely combinational unit in a floating-point datapath. It covers the two-operand operations that do no arithmetic. Operands are held in 64-bit registers and may be single or double precision. One 3-bit operation code drives all of the unit's outputs at once.

The integer-side output carries a compare result. The FP-side output carries one of three things: a minimum or maximum, a sign-injected copy of the first operand, or the raw bits of an integer source moved onto the FP side. A single invalid-operation flag reports the IEEE 754 exceptions that these operations can raise.

Operands and results travel in the same cycle. The surrounding pipeline registers the inputs before this unit and the outputs after it.

Top module: `fpcmp_unit`

## Requirements
- R1: Operation codes drive the integer output `int_res_o` as follows. Code 3'b010 gives equal, 3'b001 gives less-than and 3'b011 gives less-or-equal. The result is bit 0 and all higher bits are 0. Any other code gives 0 on this output.
- R2: A compare that involves a NaN returns 0. Equal raises `invalid_o` only when an operand is a signaling NaN. Less-than and less-or-equal raise `invalid_o` for any NaN operand.
- R3: In the compare codes, +0 and -0 are equal. Neither is less than the other.
- R4: Code 3'b110 puts the minimum and code 3'b101 puts the maximum on `fp_res_o`. In this ordering -0 is below +0.
- R5: Min and max return the other operand when exactly one input is NaN. When both inputs are NaN they return the canonical quiet NaN: 0x7FF8000000000000 for double, 0xFFFFFFFF7FC00000 for single. A signaling NaN input raises `invalid_o`.
- R6: The sign-injection codes return X's magnitude with a new sign. Code 3'b000 uses Y's sign, 3'b001 uses the inverted sign of Y, and 3'b010 uses the XOR of both signs. The sign is bit 63 for double and bit 31 for single.
- R7: Code 3'b011 moves `int_src_i` onto `fp_res_o` unchanged for double. For single it moves the low 32 bits, with the upper 32 bits set to all ones.
- R8: `dbl_i`=0 selects single precision (value in bits 31:0) and `dbl_i`=1 selects double precision. Every single-precision FP-side result has bits 63:32 all ones.
- R9: A single-precision input whose bits 63:32 are not all ones is used as the canonical quiet NaN 0x7FC00000.
- R10: Codes 3'b100 and 3'b111 drive both outputs to zero and leave `invalid_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 64 | First FP operand (X) |
| y_i | input | 64 | Second FP operand (Y) |
| op_i | input | 3 | Operation code |
| dbl_i | input | 1 | Format: 0 single, 1 double |
| int_src_i | input | XLEN | Integer source for the move operation |
| int_res_o | output | XLEN | Compare result, zero-extended |
| fp_res_o | output | 64 | Min/max, sign-injection or move result |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
All three results depend only on the present inputs, so each is due in the same cycle as its stimulus, zero register stages later. The bench changes the inputs just after a rising edge and reads all outputs at the next falling edge, half a period later. By then the combinational paths have settled and no edge ordering can interfere. Expected values come from a reference that decodes operands into real numbers and orders them with ordinary real comparisons. The +0/-0 and NaN rules are applied on top of that.

// File: rtl/fpcmp_pkg.sv
`timescale 1ns/1ps
// Shared formats, operation codes and the unpacked-operand type for the
// FP compare / min-max / sign-injection unit. Assumes IEEE 754 binary32
// and binary64 layouts, with binary32 NaN-boxed in the upper half.
package fpcmp_pkg;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
    localparam int FLEN     = DP_W;
    localparam int MAG_W    = DP_W - 1;
    localparam int BOX_W    = FLEN - SP_W;

    localparam logic [SP_W-1:0] SP_QNAN = {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_MAN_W-1){1'b0}}};
    localparam logic [DP_W-1:0] DP_QNAN = {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_MAN_W-1){1'b0}}};

    // Codes overlap on purpose: one code drives both result sides.
    localparam logic [2:0] OP_SGNJ  = 3'b000;
    localparam logic [2:0] OP_SGNJN = 3'b001;
    localparam logic [2:0] OP_SGNJX = 3'b010;
    localparam logic [2:0] OP_MOVE  = 3'b011;
    localparam logic [2:0] OP_EQ    = 3'b010;
    localparam logic [2:0] OP_LT    = 3'b001;
    localparam logic [2:0] OP_LE    = 3'b011;
    localparam logic [2:0] OP_MAX   = 3'b101;
    localparam logic [2:0] OP_MIN   = 3'b110;

    typedef enum logic [1:0] {
        SEL_SGNJ   = 2'b00,
        SEL_MOVE   = 2'b01,
        SEL_MINMAX = 2'b10,
        SEL_NONE   = 2'b11
    } fp_sel_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;   // exponent and fraction, zero-extended for single
        logic             nan;
        logic             snan;
        logic             zero;
    } fp_info_t;
endpackage

// File: rtl/fpcmp_unpack.sv
`timescale 1ns/1ps
// Operand unpacker. It picks the active format, replaces an improperly boxed
// single with the canonical quiet NaN and classifies the value. It assumes
// dbl_i is stable for the operation and needs no clock.
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  logic [FLEN-1:0] raw_i,
    input  logic            dbl_i,
    output fp_info_t        info_o,
    output logic [FLEN-1:0] canon_o
);
    // Split the operand in its own format and classify it.
    always_comb begin
        logic [SP_W-1:0] sp;
        logic            exp_ones;
        logic            exp_zero;
        logic            man_nz;
        logic            quiet;
        sp = (&raw_i[FLEN-1:SP_W]) ? raw_i[SP_W-1:0] : SP_QNAN;
        if (dbl_i) begin
            info_o.sign = raw_i[FLEN-1];
            info_o.mag  = raw_i[MAG_W-1:0];
            exp_ones    = &raw_i[FLEN-2 -: DP_EXP_W];
            exp_zero    = ~|raw_i[FLEN-2 -: DP_EXP_W];
            man_nz      = |raw_i[DP_MAN_W-1:0];
            quiet       = raw_i[DP_MAN_W-1];
            canon_o     = raw_i;
        end else begin
            info_o.sign = sp[SP_W-1];
            info_o.mag  = MAG_W'(sp[SP_W-2:0]);
            exp_ones    = &sp[SP_W-2 -: SP_EXP_W];
            exp_zero    = ~|sp[SP_W-2 -: SP_EXP_W];
            man_nz      = |sp[SP_MAN_W-1:0];
            quiet       = sp[SP_MAN_W-1];
            canon_o     = {{BOX_W{1'b1}}, sp};
        end
        info_o.nan  = exp_ones & man_nz;
        info_o.snan = exp_ones & man_nz & ~quiet;
        info_o.zero = exp_zero & ~man_nz;
    end
endmodule

// File: rtl/fpcmp_order.sv
`timescale 1ns/1ps
// Ordering core. It produces the equal / less-than / less-or-equal compares
// (signed zeros equal) and min / max (-0 below +0) with IEEE NaN rules, plus
// the NaN summaries that the flag logic needs. Inputs come from fpcmp_unpack.
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fp_info_t        a_i,
    input  fp_info_t        b_i,
    input  logic [FLEN-1:0] a_val_i,
    input  logic [FLEN-1:0] b_val_i,
    input  logic            dbl_i,
    output logic            eq_o,
    output logic            lt_o,
    output logic            le_o,
    output logic [FLEN-1:0] min_o,
    output logic [FLEN-1:0] max_o,
    output logic            any_nan_o,
    output logic            any_snan_o
);
    logic below;      // a strictly before b, -0 before +0
    logic same_bits;
    logic both_zero;
    logic [FLEN-1:0] canon_nan;

    // Sign-magnitude ordering shared by compare and min/max.
    always_comb begin
        if (a_i.sign != b_i.sign) below = a_i.sign;
        else if (a_i.sign)        below = a_i.mag > b_i.mag;
        else                      below = a_i.mag < b_i.mag;
        same_bits  = (a_i.sign == b_i.sign) && (a_i.mag == b_i.mag);
        both_zero  = a_i.zero & b_i.zero;
        any_nan_o  = a_i.nan | b_i.nan;
        any_snan_o = a_i.snan | b_i.snan;
        canon_nan  = dbl_i ? DP_QNAN : {{BOX_W{1'b1}}, SP_QNAN};
    end

    // Quiet/signaling compares: unordered operands give 0.
    always_comb begin
        eq_o = ~any_nan_o & (both_zero | same_bits);
        lt_o = ~any_nan_o & ~both_zero & below;
        le_o = eq_o | lt_o;
    end

    // Min / max selection with NaN substitution.
    always_comb begin
        if (a_i.nan && b_i.nan) begin
            min_o = canon_nan;
            max_o = canon_nan;
        end else if (a_i.nan) begin
            min_o = b_val_i;
            max_o = b_val_i;
        end else if (b_i.nan) begin
            min_o = a_val_i;
            max_o = a_val_i;
        end else begin
            min_o = below ? a_val_i : b_val_i;
            max_o = below ? b_val_i : a_val_i;
        end
    end

    // Local checks on the ordering outputs.
    always_comb begin
        AST_CMP_EXCLUSIVE: assert (!(eq_o && lt_o)); // R1
        if (any_nan_o) begin
            AST_NAN_UNORDERED: assert (!le_o); // R2
        end
        if (both_zero && !any_nan_o) begin
            AST_ZERO_EQUAL: assert (eq_o && !lt_o); // R3
        end
        if (!any_nan_o && !same_bits) begin
            AST_MINMAX_SPLIT: assert (min_o != max_o); // R4
        end
    end
endmodule

// File: rtl/fpcmp_sgnj.sv
`timescale 1ns/1ps
// Sign injection. It returns X's canonical bits with the sign replaced by
// Y's sign, its inverse, or the XOR of both. It assumes x_val_i is already
// NaN-boxed for single precision.
module fpcmp_sgnj
    import fpcmp_pkg::*;
(
    input  logic [FLEN-1:0] x_val_i,
    input  logic            y_sign_i,
    input  logic            dbl_i,
    input  logic [1:0]      mode_i,
    output logic [FLEN-1:0] res_o
);
    logic x_sign;
    logic new_sign;

    // Choose the injected sign.
    always_comb begin
        x_sign = dbl_i ? x_val_i[FLEN-1] : x_val_i[SP_W-1];
        unique case (mode_i)
            2'b00:   new_sign = y_sign_i;
            2'b01:   new_sign = ~y_sign_i;
            2'b10:   new_sign = x_sign ^ y_sign_i;
            default: new_sign = x_sign;
        endcase
    end

    // Place the sign at the active format's sign position.
    always_comb begin
        res_o = x_val_i;
        if (dbl_i) res_o[FLEN-1] = new_sign;
        else       res_o[SP_W-1] = new_sign;
    end

    always_comb begin
        if (dbl_i) begin
            AST_SGNJ_MAG_KEPT: assert (res_o[MAG_W-1:0] == x_val_i[MAG_W-1:0]); // R6
        end else begin
            AST_SGNJ_SP_KEPT: assert (res_o[SP_W-2:0] == x_val_i[SP_W-2:0]
                                      && res_o[FLEN-1:SP_W] == x_val_i[FLEN-1:SP_W]); // R6
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
`timescale 1ns/1ps
// Top of the FP compare / min-max / sign-injection unit. It is purely
// combinational. One operation code drives both result sides, and the FP-side
// mux is steered by {op[2], op[1]&op[0]}. It assumes XLEN >= 32.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [FLEN-1:0] x_i,
    input  logic [FLEN-1:0] y_i,
    input  logic [2:0]      op_i,
    input  logic            dbl_i,
    input  logic [XLEN-1:0] int_src_i,
    output logic [XLEN-1:0] int_res_o,
    output logic [FLEN-1:0] fp_res_o,
    output logic            invalid_o
);
    localparam int NUM_OPS = 2;

    fp_info_t        info [NUM_OPS];
    logic [FLEN-1:0] val  [NUM_OPS];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_unpack
        fpcmp_unpack u_unpack (
            .raw_i   ((g == 0) ? x_i : y_i),
            .dbl_i   (dbl_i),
            .info_o  (info[g]),
            .canon_o (val[g])
        );
    end

    logic            eq, lt, le, any_nan, any_snan;
    logic [FLEN-1:0] min_v, max_v, sgnj_v, move_v;
    fp_sel_e         sel;
    logic            unlisted;

    fpcmp_order u_order (
        .a_i        (info[0]),
        .b_i        (info[1]),
        .a_val_i    (val[0]),
        .b_val_i    (val[1]),
        .dbl_i      (dbl_i),
        .eq_o       (eq),
        .lt_o       (lt),
        .le_o       (le),
        .min_o      (min_v),
        .max_o      (max_v),
        .any_nan_o  (any_nan),
        .any_snan_o (any_snan)
    );

    fpcmp_sgnj u_sgnj (
        .x_val_i  (val[0]),
        .y_sign_i (info[1].sign),
        .dbl_i    (dbl_i),
        .mode_i   (op_i[1:0]),
        .res_o    (sgnj_v)
    );

    // Raw move of integer bits, NaN-boxed for single.
    always_comb begin
        move_v = dbl_i ? FLEN'(int_src_i) : {{BOX_W{1'b1}}, int_src_i[SP_W-1:0]};
    end

    // FP-side selector and result mux.
    always_comb begin
        sel      = fp_sel_e'({op_i[2], op_i[1] & op_i[0]});
        unlisted = (op_i == 3'b100) || (op_i == 3'b111);
        unique case (sel)
            SEL_SGNJ:   fp_res_o = sgnj_v;
            SEL_MOVE:   fp_res_o = move_v;
            SEL_MINMAX: fp_res_o = unlisted ? '0 : (op_i[0] ? max_v : min_v);
            default:    fp_res_o = '0;
        endcase
    end

    // Integer-side compare result and the invalid flag.
    always_comb begin
        int_res_o = '0;
        invalid_o = 1'b0;
        unique case (op_i)
            OP_EQ: begin int_res_o[0] = eq; invalid_o = any_snan; end
            OP_LT: begin int_res_o[0] = lt; invalid_o = any_nan;  end
            OP_LE: begin int_res_o[0] = le; invalid_o = any_nan;  end
            OP_MIN, OP_MAX: invalid_o = any_snan;
            default: ;
        endcase
    end

    always_comb begin
        AST_INT_NARROW: assert (int_res_o[XLEN-1:1] == '0); // R1
        if (!dbl_i && !unlisted) begin
            AST_SP_BOXED: assert (&fp_res_o[FLEN-1:SP_W]); // R8
        end
        if (unlisted) begin
            AST_UNLISTED_SILENT: assert (fp_res_o == '0 && int_res_o == '0 && !invalid_o); // R10
        end
        if (op_i == OP_MOVE && dbl_i) begin
            AST_MOVE_BITS: assert (fp_res_o == FLEN'(int_src_i)); // R7
        end
    end
endmodule

// File: tb/fpcmp_unit_tb.sv
`timescale 1ns/1ps
module fpcmp_unit_tb;
    localparam real CLK_PERIOD = 8.0;
    localparam int  XLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2.0) clk = ~clk;

    logic [63:0]     x, y, fp_res;
    logic [2:0]      op;
    logic            dbl, invalid;
    logic [XLEN-1:0] int_src, int_res;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    fpcmp_unit #(.XLEN(XLEN)) u_dut (
        .x_i(x), .y_i(y), .op_i(op), .dbl_i(dbl), .int_src_i(int_src),
        .int_res_o(int_res), .fp_res_o(fp_res), .invalid_o(invalid)
    );

    function automatic real p2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    // Reference decode into a real value plus NaN classification.
    task automatic decode(input logic [63:0] v, input bit d, output bit nan,
                          output bit snan, output bit neg, output real r);
        if (d) begin
            nan  = (v[62:52] == 11'h7FF) && (v[51:0] != 0);
            snan = nan && !v[51];
            neg  = v[63];
            r    = nan ? 0.0 : $bitstoreal(v);
        end else if (v[63:32] != 32'hFFFF_FFFF) begin
            nan = 1; snan = 0; neg = 0; r = 0.0;   // R9: improper box
        end else begin
            nan  = (v[30:23] == 8'hFF) && (v[22:0] != 0);
            snan = nan && !v[22];
            neg  = v[31];
            if (nan)                 r = 0.0;
            else if (v[30:23] == 8'hFF) r = $bitstoreal(64'h7FF0_0000_0000_0000);
            else if (v[30:23] == 0)  r = real'(v[22:0]) * p2(-149);
            else                     r = real'({1'b1, v[22:0]}) * p2(int'(v[30:23]) - 150);
            if (neg) r = -r;
        end
    endtask

    function automatic logic [63:0] corner(int i, bit d);
        logic [63:0] dv [12] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
            64'hBFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
            64'h1, 64'h800F_FFFF_FFFF_FFFF, 64'h7FF8_0000_0000_0000, 64'h7FF4_0000_0000_0000,
            64'hFFF0_0000_0000_0001, 64'h7FEF_FFFF_FFFF_FFFF};
        logic [31:0] sv [12] = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
            32'h7F80_0000, 32'hFF80_0000, 32'h1, 32'h807F_FFFF, 32'h7FC0_0000,
            32'h7FA0_0000, 32'h3F80_0000, 32'h7F7F_FFFF};
        if (d) return dv[i];
        if (i == 10) return {32'h0, sv[i]};          // improperly boxed one
        return {32'hFFFF_FFFF, sv[i]};
    endfunction

    function automatic logic [63:0] box(logic [63:0] v, bit d);
        return d ? v : {32'hFFFF_FFFF, v[31:0]};
    endfunction

    task automatic check(string what, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s op=%b dbl=%0b x=%h y=%h actual=%h expected=%h",
                     tag, what, op, dbl, x, y, act, exp);
        end
    endtask

    task automatic run_vec(logic [63:0] a, logic [63:0] b, logic [2:0] o, bit d, logic [63:0] src);
        bit xn, xs, xg, yn, ys, yg;
        real rx, ry;
        logic [63:0] e_fp, lo, hi, canon, xv;
        logic        e_int, e_inv, sgn, ysg;
        string tag_i, tag_f;
        @(posedge clk);
        x = a; y = b; op = o; dbl = d; int_src = src;
        decode(a, d, xn, xs, xg, rx);
        decode(b, d, yn, ys, yg, ry);
        canon = d ? 64'h7FF8_0000_0000_0000 : 64'hFFFF_FFFF_7FC0_0000;
        e_int = 0; e_inv = 0; e_fp = 0;
        tag_i = (xn || yn) ? "R2" : ((rx == 0.0 && ry == 0.0) ? "R3" : "R1");
        tag_f = "R10";
        case (o)
            3'b001: begin e_int = !(xn || yn) && rx < ry;  e_inv = xn || yn; end
            3'b010: begin e_int = !(xn || yn) && rx == ry; e_inv = xs || ys; end
            3'b011: begin e_int = !(xn || yn) && rx <= ry; e_inv = xn || yn; end
            default: ;
        endcase
        if (o == 3'b000 || o == 3'b100 || o == 3'b111 || o[2]) tag_i = "R1";
        if (o[2] == 0 && o != 3'b011) begin
            xv  = d ? a : ((a[63:32] == 32'hFFFF_FFFF) ? a : 64'hFFFF_FFFF_7FC0_0000);
            ysg = d ? b[63] : ((b[63:32] == 32'hFFFF_FFFF) ? b[31] : 1'b0);
            sgn = (o == 3'b000) ? ysg : (o == 3'b001) ? !ysg : (ysg ^ (d ? xv[63] : xv[31]));
            if (d) e_fp = {sgn, xv[62:0]};
            else   e_fp = {32'hFFFF_FFFF, sgn, xv[30:0]};
            tag_f = "R6";
        end else if (o == 3'b011) begin
            e_fp = d ? src : {32'hFFFF_FFFF, src[31:0]};
            tag_f = "R7";
        end else if (o == 3'b101 || o == 3'b110) begin
            e_inv = xs || ys;
            if (xn && yn)  begin lo = canon; hi = canon; end
            else if (xn)   begin lo = box(b, d); hi = lo; end
            else if (yn)   begin lo = box(a, d); hi = lo; end
            else if (rx < ry) begin lo = box(a, d); hi = box(b, d); end
            else if (ry < rx) begin lo = box(b, d); hi = box(a, d); end
            else if (rx == 0.0) begin
                lo = xg ? box(a, d) : box(b, d);
                hi = xg ? box(b, d) : box(a, d);
            end else begin lo = box(a, d); hi = lo; end
            e_fp  = (o == 3'b110) ? lo : hi;
            tag_f = (xn || yn) ? "R5" : "R4";
        end
        if (!d && o != 3'b100 && o != 3'b111) tag_f = {tag_f, "/R8"};
        if (!d && (a[63:32] != 32'hFFFF_FFFF || b[63:32] != 32'hFFFF_FFFF)) tag_f = {tag_f, "/R9"};
        @(negedge clk);
        check("int_res", tag_i, int_res, {63'b0, e_int});
        check("fp_res", tag_f, fp_res, e_fp);
        check("invalid", (o[2] ? tag_f : tag_i), {63'b0, invalid}, {63'b0, e_inv});
    endtask

    function automatic logic [63:0] rnd_operand(bit d);
        logic [63:0] v;
        if ($urandom % 4 == 0) return corner(int'($urandom % 12), d);
        v = {$urandom, $urandom};
        if (!d && ($urandom % 8 != 0)) v[63:32] = 32'hFFFF_FFFF;
        return v;
    endfunction

    initial begin
        logic [63:0] a, b;
        bit d;
        void'($urandom(32'd1357));
        x = '0; y = '0; op = '0; dbl = 0; int_src = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: unboxed zeros act as canonical NaNs (R9), sign-inject keeps it.
        @(negedge clk);
        check("idle fp_res", "R9", fp_res, 64'hFFFF_FFFF_7FC0_0000);
        check("idle int_res", "R1", int_res, 64'h0);
        // Directed corner sweep in both formats.
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    for (int o = 0; o < 8; o++)
                        run_vec(corner(i, f[0]), corner(j, f[0]), 3'(o), f[0],
                                {$urandom, $urandom});
        // Constrained random, with some equal and neighbouring pairs.
        for (int n = 0; n < 3000; n++) begin
            d = $urandom % 2;
            a = rnd_operand(d);
            case ($urandom % 4)
                0: b = a;
                1: b = a ^ 64'h1;
                default: b = rnd_operand(d);
            endcase
            run_vec(a, b, 3'($urandom % 8), d, {$urandom, $urandom});
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule